// File: doc/BRIEF.md
# Hot-Swap Sequencing Controller

This block is the digital sequencer behind a hot-swap power switch. It takes the outputs of analog comparators that are already synchronized to its clock: supply above the lockout level, the ON request, sense voltage above the fault-timing level, sense voltage above the fast-trip level, and the timer node above its high threshold or below its low threshold. From these it selects one current source for the shared timer capacitor and one drive mode for the external FET gate.

A single timer node does three jobs in turn. It sets the insertion delay after power-up, it integrates the time spent in overcurrent, and in the auto-retry variant it times the cool-down between attempts. A parameter selects auto-retry or latch-off. The ON request passes through a glitch filter counted in clock cycles. A software-off input forces the switch off. The block also gives a one-cycle fault pulse and a level flag that is high during cool-down or latch-off.

Top module: `hsw_seq_ctrl`

## Requirements
- R1: While `supply_ok` is low, the block reaches the lockout state at the next clock edge. In that state `gate_mode` is 4 (strong clamp) and `tmr_src` is 4 (strong pull-down), whatever the other inputs are. Reset also enters this state, with `fault_pulse` and `off_hold` low.
- R2: After the supply comes up, an insertion delay runs first. During its first phase `tmr_src` is 1 (small pull-up) until `tmr_hi` is seen. During its second phase `tmr_src` is 4 until `tmr_lo` is seen. `gate_mode` stays 3 (normal pull-down) in both phases, and the ON request has no effect.
- R3: Once the delay is over, the gate stays at 3 until the filtered ON request is high and `sw_off` is low. After that, `gate_mode` becomes 0 (pull-up) and `tmr_src` is 4.
- R4: The filtered ON request takes a new level of `on_req` only after that level has been sampled on FILT_CYC consecutive edges. A shorter excursion has no effect.
- R5: In an active state, `sense_oc` high gives `gate_mode` 1 (regulate) and `tmr_src` 2 (large pull-up). When `sense_oc` goes low, `gate_mode` becomes 2 (full enhance) and `tmr_src` becomes 4.
- R6: If `tmr_hi` is seen while `sense_oc` is still high, a fault is declared. `fault_pulse` is high for exactly one cycle, `gate_mode` becomes 3 and `off_hold` goes high.
- R7: In the retry variant (RETRY=1), the fault is followed by a cool-down with `tmr_src` 3 (weak pull-down). When `tmr_lo` is seen, the gate returns to 0 and `off_hold` clears.
- R8: In the latch-off variant (RETRY=0), the fault leaves `gate_mode` at 3 and `tmr_src` at 4. This holds until the filtered ON request goes low and then high again.
- R9: In the ramp, limit and on states, `sense_fast` high turns `gate_mode` to 3 in the same cycle, without waiting for a clock edge.
- R10: `sw_off` high, or the filtered ON request low, sends every post-delay state to idle at the next edge. In idle `gate_mode` is 3 and `tmr_src` is 4.
- R11: With a timer node that integrates the selected current, the cool-down lasts longer than the fault-timing phase. This is because the weak pull-down is much smaller than the large pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above the lockout level |
| on_req | input | 1 | ON request before the glitch filter |
| sw_off | input | 1 | Software off request |
| sense_oc | input | 1 | Sense voltage above the fault-timing level |
| sense_fast | input | 1 | Sense voltage above the fast-trip level |
| tmr_hi | input | 1 | Timer node above its high threshold |
| tmr_lo | input | 1 | Timer node below its low threshold |
| tmr_src | output | 3 | Timer source: 0 none, 1 small up, 2 large up, 3 weak down, 4 strong down |
| gate_mode | output | 3 | Gate: 0 pull-up, 1 regulate, 2 enhance, 3 pull-down, 4 strong clamp |
| fault_pulse | output | 1 | One-cycle pulse when an overcurrent fault is declared |
| off_hold | output | 1 | High during cool-down or latch-off |

## Verification
Every sequencer state has its own pair of timer and gate codes, so a wrong state shows on the two output buses one cycle after the edge that chose it. One exception needs care: idle, the second delay phase and latch-off share the same pair. These are told apart by when the gate is released and by `off_hold`. A wrong transition would release the gate too early or never, would keep a pull-up on the timer past its threshold, or would give a cool-down no longer than the fault window. A timer-node model in the bench makes those durations measurable at the ports.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    // Timer current source select, driven onto tmr_src
    typedef enum logic [2:0] {
        TS_NONE      = 3'd0,
        TS_UP_SMALL  = 3'd1,
        TS_UP_LARGE  = 3'd2,
        TS_DN_WEAK   = 3'd3,
        TS_DN_STRONG = 3'd4
    } tmr_src_e;

    // Gate drive mode, driven onto gate_mode
    typedef enum logic [2:0] {
        GD_PULLUP   = 3'd0,
        GD_REGULATE = 3'd1,
        GD_ENHANCE  = 3'd2,
        GD_PULLDN   = 3'd3,
        GD_CLAMP    = 3'd4
    } gate_drv_e;

    typedef enum logic [3:0] {
        ST_UVLO,
        ST_INIT_CHG,
        ST_INIT_DIS,
        ST_IDLE,
        ST_RAMP,
        ST_LIMIT,
        ST_ON,
        ST_COOL,
        ST_LATCH
    } seq_st_e;

    typedef struct packed {
        tmr_src_e  tmr;
        gate_drv_e gate;
    } drive_t;

    // States in which the FET may conduct
    function automatic logic st_powered(seq_st_e s);
        return (s == ST_RAMP) || (s == ST_LIMIT) || (s == ST_ON);
    endfunction

    // States that ON low or software off send back to idle
    function automatic logic st_on_gated(seq_st_e s);
        return st_powered(s) || (s == ST_COOL) || (s == ST_LATCH);
    endfunction

endpackage

// File: rtl/hsw_on_filter.sv
module hsw_on_filter #(
    parameter int unsigned FILT_CYC = 750
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_cnt;

    // clean follows raw after FILT_CYC consecutive samples of a new level
    always_ff @(posedge clk) begin
        if (rst) begin
            clean   <= 1'b0;
            run_cnt <= '0;
        end else if (raw == clean) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            clean   <= raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/hsw_fsm.sv
module hsw_fsm
    import hsw_pkg::*;
#(
    parameter bit RETRY = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    supply_ok,
    input  logic    on_ok,
    input  logic    sw_off,
    input  logic    oc_timing,
    input  logic    tmr_hi,
    input  logic    tmr_lo,
    output seq_st_e st,
    output logic    fault_pulse,
    output logic    off_hold
);
    localparam seq_st_e FAULT_DEST = RETRY ? ST_COOL : ST_LATCH;

    seq_st_e nxt;

    always_comb begin
        nxt = st;
        if (!supply_ok) begin
            nxt = ST_UVLO;
        end else if (st_on_gated(st) && (!on_ok || sw_off)) begin
            nxt = ST_IDLE;
        end else begin
            case (st)
                ST_UVLO:     nxt = ST_INIT_CHG;
                ST_INIT_CHG: if (tmr_hi) nxt = ST_INIT_DIS;
                ST_INIT_DIS: if (tmr_lo) nxt = ST_IDLE;
                ST_IDLE:     if (on_ok && !sw_off) nxt = ST_RAMP;
                ST_RAMP:     if (oc_timing) nxt = ST_LIMIT;
                ST_LIMIT: begin
                    if (!oc_timing)  nxt = ST_ON;
                    else if (tmr_hi) nxt = FAULT_DEST;
                end
                ST_ON:       if (oc_timing) nxt = ST_LIMIT;
                ST_COOL:     if (tmr_lo) nxt = ST_RAMP;
                ST_LATCH:    nxt = ST_LATCH;
                default:     nxt = ST_UVLO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_UVLO;
            fault_pulse <= 1'b0;
        end else begin
            st          <= nxt;
            fault_pulse <= (st == ST_LIMIT) && (nxt == FAULT_DEST);
        end
    end

    assign off_hold = (st == ST_COOL) || (st == ST_LATCH);
endmodule

// File: rtl/hsw_drive_dec.sv
module hsw_drive_dec
    import hsw_pkg::*;
(
    input  seq_st_e st,
    input  logic    fast_trip,
    output drive_t  drv
);
    always_comb begin
        drv = '{tmr: TS_DN_STRONG, gate: GD_PULLDN};
        case (st)
            ST_UVLO:     drv = '{tmr: TS_DN_STRONG, gate: GD_CLAMP};
            ST_INIT_CHG: drv = '{tmr: TS_UP_SMALL,  gate: GD_PULLDN};
            ST_RAMP:     drv = '{tmr: TS_DN_STRONG, gate: GD_PULLUP};
            ST_LIMIT:    drv = '{tmr: TS_UP_LARGE,  gate: GD_REGULATE};
            ST_ON:       drv = '{tmr: TS_DN_STRONG, gate: GD_ENHANCE};
            ST_COOL:     drv = '{tmr: TS_DN_WEAK,   gate: GD_PULLDN};
            default:     drv = '{tmr: TS_DN_STRONG, gate: GD_PULLDN};
        endcase
        // fast trip overrides the gate without waiting for an edge
        if (st_powered(st) && fast_trip) begin
            drv.gate = GD_PULLDN;
        end
    end
endmodule

// File: rtl/hsw_seq_ctrl.sv
module hsw_seq_ctrl
    import hsw_pkg::*;
#(
    parameter bit          RETRY    = 1'b1,
    parameter int unsigned FILT_CYC = 750
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       on_req,
    input  logic       sw_off,
    input  logic       sense_oc,
    input  logic       sense_fast,
    input  logic       tmr_hi,
    input  logic       tmr_lo,
    output logic [2:0] tmr_src,
    output logic [2:0] gate_mode,
    output logic       fault_pulse,
    output logic       off_hold
);
    logic    on_ok;
    seq_st_e st;
    drive_t  drv;

    hsw_on_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .raw   (on_req),
        .clean (on_ok)
    );

    hsw_fsm #(.RETRY(RETRY)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .on_ok       (on_ok),
        .sw_off      (sw_off),
        .oc_timing   (sense_oc),
        .tmr_hi      (tmr_hi),
        .tmr_lo      (tmr_lo),
        .st          (st),
        .fault_pulse (fault_pulse),
        .off_hold    (off_hold)
    );

    hsw_drive_dec u_dec (
        .st        (st),
        .fast_trip (sense_fast),
        .drv       (drv)
    );

    assign tmr_src   = drv.tmr;
    assign gate_mode = drv.gate;
endmodule

// File: rtl/hsw_seq_chk.sv
module hsw_seq_chk
    import hsw_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic       sense_fast,
    input logic       sw_off,
    input logic [2:0] gate_mode,
    input logic [2:0] tmr_src,
    input logic       fault_pulse,
    input logic       off_hold
);
    // R1
    uvlo_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (gate_mode == GD_CLAMP && tmr_src == TS_DN_STRONG));

    // R5
    limit_timer_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_mode == GD_REGULATE) |-> (tmr_src == TS_UP_LARGE));

    // R6
    fault_single_chk: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |=> !fault_pulse);

    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> (off_hold && gate_mode == GD_PULLDN));

    // R9
    fast_trip_chk: assert property (@(posedge clk) disable iff (rst)
        sense_fast |-> (gate_mode == GD_PULLDN || gate_mode == GD_CLAMP));

    // R10
    sw_off_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_off && $past(sw_off)) |-> (gate_mode == GD_PULLDN || gate_mode == GD_CLAMP));
endmodule

bind hsw_seq_ctrl hsw_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .supply_ok   (supply_ok),
    .sense_fast  (sense_fast),
    .sw_off      (sw_off),
    .gate_mode   (gate_mode),
    .tmr_src     (tmr_src),
    .fault_pulse (fault_pulse),
    .off_hold    (off_hold)
);

// File: tb/hsw_seq_ctrl_test.sv
`timescale 1ns/1ps
module hsw_seq_ctrl_test;
    localparam int FILT = 16;
    localparam int VHI  = 1300;
    localparam int VLO  = 200;
    localparam int VMAX = 1400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply = 1'b0;
    logic on_a = 0, sw_a = 0, oc_a = 0, fast_a = 0;
    logic on_b = 0, sw_b = 0, oc_b = 0, fast_b = 0;
    logic hi_a, lo_a, hi_b, lo_b;
    logic [2:0] ts_a, gm_a, ts_b, gm_b;
    logic fp_a, oh_a, fp_b, oh_b;
    int vt_a = 0, vt_b = 0;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    hsw_seq_ctrl #(.RETRY(1'b1), .FILT_CYC(FILT)) uut (
        .clk(clk), .rst(rst), .supply_ok(supply), .on_req(on_a), .sw_off(sw_a),
        .sense_oc(oc_a), .sense_fast(fast_a), .tmr_hi(hi_a), .tmr_lo(lo_a),
        .tmr_src(ts_a), .gate_mode(gm_a), .fault_pulse(fp_a), .off_hold(oh_a));

    hsw_seq_ctrl #(.RETRY(1'b0), .FILT_CYC(FILT)) uut_lat (
        .clk(clk), .rst(rst), .supply_ok(supply), .on_req(on_b), .sw_off(sw_b),
        .sense_oc(oc_b), .sense_fast(fast_b), .tmr_hi(hi_b), .tmr_lo(lo_b),
        .tmr_src(ts_b), .gate_mode(gm_b), .fault_pulse(fp_b), .off_hold(oh_b));

    // timer node model: slope per selected source
    function automatic int slope(logic [2:0] ts);
        case (ts)
            3'd1: return 1;
            3'd2: return 30;
            3'd3: return -1;
            3'd4: return -20;
            default: return 0;
        endcase
    endfunction

    function automatic int clampv(int v);
        if (v < 0) return 0;
        if (v > VMAX) return VMAX;
        return v;
    endfunction

    always @(posedge clk) begin
        vt_a <= clampv(vt_a + slope(ts_a));
        vt_b <= clampv(vt_b + slope(ts_b));
    end
    assign hi_a = (vt_a >= VHI);
    assign lo_a = (vt_a <= VLO);
    assign hi_b = (vt_b >= VHI);
    assign lo_b = (vt_b <= VLO);

    function automatic logic [2:0] exp_gate(logic oc, logic fast);
        if (fast) return 3'd3;
        return oc ? 3'd1 : 3'd2;
    endfunction

    function automatic logic [2:0] exp_tmr(logic oc);
        return oc ? 3'd2 : 3'd4;
    endfunction

    function automatic logic [2:0] pick(int sel);
        case (sel)
            0: return ts_a;
            1: return gm_a;
            2: return gm_b;
            default: return ts_b;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [2:0] act, logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_true(string req, string what, bit ok, int a, int e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, a, e);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_while(int sel, logic [2:0] val, output int n);
        n = 0;
        while (pick(sel) == val && n < 5000) begin
            tick();
            n++;
        end
        chk_true("wait", "timeout", n < 5000, n, 5000);
    endtask

    initial begin
        int n;
        int fcnt;
        int ccnt;
        int blen;
        int glen;
        void'($urandom(32'd1177));
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1", "reset gate", gm_a, 3'd4);
        chk("R1", "reset timer", ts_a, 3'd4);
        chk("R1", "reset fault", 3'(fp_a), 3'd0);
        chk("R1", "reset hold", 3'(oh_a), 3'd0);
        chk("R1", "reset gate latch", gm_b, 3'd4);
        on_a = 1'b1;
        repeat (FILT + 2) tick();
        chk("R1", "on ignored in lockout", gm_a, 3'd4);

        // R2 insertion delay
        supply = 1'b1;
        tick();
        chk("R2", "charge timer", ts_a, 3'd1);
        chk("R2", "gate held", gm_a, 3'd3);
        wait_while(0, 3'd1, n);
        chk("R2", "discharge timer", ts_a, 3'd4);
        chk("R2", "gate held in discharge", gm_a, 3'd3);
        chk_true("R2", "charge length", n >= 1295 && n <= 1305, n, 1301);
        wait_while(1, 3'd3, n);
        // R3 gate release
        chk("R3", "gate pull-up", gm_a, 3'd0);
        chk("R3", "timer in ramp", ts_a, 3'd4);

        // R9 fast trip in ramp, same cycle
        fast_a = 1'b1;
        #1;
        chk("R9", "fast trip ramp", gm_a, 3'd3);
        fast_a = 1'b0;
        #1;
        chk("R9", "fast trip released", gm_a, 3'd0);

        // R5 limit
        oc_a = 1'b1;
        tick();
        chk("R5", "regulate", gm_a, 3'd1);
        chk("R5", "large pull-up", ts_a, 3'd2);
        // R6 fault
        n = 0;
        while (gm_a == 3'd1 && n < 5000) begin
            tick();
            n++;
        end
        fcnt = n + 1;
        chk("R6", "fault gate", gm_a, 3'd3);
        chk("R6", "fault pulse", 3'(fp_a), 3'd1);
        chk("R7", "hold flag", 3'(oh_a), 3'd1);
        chk("R7", "weak pull-down", ts_a, 3'd3);
        oc_a = 1'b0;
        tick();
        chk("R6", "pulse single", 3'(fp_a), 3'd0);
        chk("R7", "cool gate", gm_a, 3'd3);
        wait_while(1, 3'd3, n);
        ccnt = n + 1;
        // R7 auto retry
        chk("R7", "retry gate", gm_a, 3'd0);
        chk("R7", "hold cleared", 3'(oh_a), 3'd0);
        // R11 cool-down longer than fault time
        chk_true("R11", "cool vs fault", ccnt > fcnt, ccnt, fcnt);

        // R5 enter on state
        oc_a = 1'b1;
        repeat (3) tick();
        oc_a = 1'b0;
        tick();
        chk("R5", "enhance", gm_a, 3'd2);
        chk("R5", "timer pulled down", ts_a, 3'd4);
        repeat (20) tick();

        // R5 R9 random overcurrent bursts and fast trips
        for (int i = 0; i < 40; i++) begin
            blen = 1 + int'($urandom % 8);
            glen = 16 + int'($urandom % 12);
            for (int j = 0; j < blen; j++) begin
                oc_a = 1'b1;
                fast_a = ($urandom % 4) == 0;
                tick();
                chk("R5/R9", "burst gate", gm_a, exp_gate(oc_a, fast_a));
                chk("R5", "burst timer", ts_a, exp_tmr(oc_a));
            end
            for (int j = 0; j < glen; j++) begin
                oc_a = 1'b0;
                fast_a = ($urandom % 5) == 0;
                tick();
                chk("R5/R9", "gap gate", gm_a, exp_gate(oc_a, fast_a));
                chk("R5", "gap timer", ts_a, exp_tmr(oc_a));
            end
        end
        oc_a = 1'b0;
        fast_a = 1'b0;
        tick();

        // R10 software off
        sw_a = 1'b1;
        tick();
        chk("R10", "sw off gate", gm_a, 3'd3);
        chk("R10", "sw off timer", ts_a, 3'd4);
        repeat (5) tick();
        chk("R10", "sw off holds", gm_a, 3'd3);
        sw_a = 1'b0;
        tick();
        chk("R3", "restart after sw off", gm_a, 3'd0);

        // R4 glitch filter
        on_a = 1'b0;
        for (int i = 0; i < FILT - 1; i++) begin
            tick();
            chk("R4", "short low ignored", gm_a, 3'd0);
        end
        on_a = 1'b1;
        for (int i = 0; i < FILT + 3; i++) begin
            tick();
            chk("R4", "after glitch", gm_a, 3'd0);
        end
        on_a = 1'b0;
        for (int i = 0; i < FILT; i++) begin
            tick();
            chk("R4", "filter delay", gm_a, 3'd0);
        end
        tick();
        chk("R4", "on low accepted", gm_a, 3'd3);
        chk("R10", "on low timer", ts_a, 3'd4);
        on_a = 1'b1;

        // R3 R8 latch-off variant
        chk("R3", "idle with on low", gm_b, 3'd3);
        on_b = 1'b1;
        for (int i = 0; i < FILT; i++) begin
            tick();
            chk("R3", "latch idle wait", gm_b, 3'd3);
        end
        tick();
        chk("R3", "latch gate up", gm_b, 3'd0);
        oc_b = 1'b1;
        tick();
        chk("R5", "latch regulate", gm_b, 3'd1);
        wait_while(2, 3'd1, n);
        chk("R8", "latch fault gate", gm_b, 3'd3);
        chk("R6", "latch pulse", 3'(fp_b), 3'd1);
        chk("R8", "latch hold", 3'(oh_b), 3'd1);
        chk("R8", "latch timer", ts_b, 3'd4);
        oc_b = 1'b0;
        for (int i = 0; i < 300; i++) begin
            tick();
            chk("R8", "no auto retry", gm_b, 3'd3);
        end
        on_b = 1'b0;
        repeat (FILT + 1) tick();
        chk("R8", "idle after on low", gm_b, 3'd3);
        chk("R8", "hold cleared", 3'(oh_b), 3'd0);
        on_b = 1'b1;
        repeat (FILT + 1) tick();
        chk("R8", "restart after toggle", gm_b, 3'd0);

        // R1 supply loss
        supply = 1'b0;
        tick();
        chk("R1", "loss gate", gm_a, 3'd4);
        chk("R1", "loss timer", ts_a, 3'd4);
        chk("R1", "loss gate latch", gm_b, 3'd4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule